// File: doc/BRIEF.md
# Double-Buffered Decimal Tuning-Word Loader

This block is the host-facing write port of a decimal numerically controlled oscillator. A host places a frequency word (35 bits, nine 1-2-4-8 BCD digits with a 3-bit top digit) and a 3-bit phase offset on its buses and pulses a write strobe. The data lands in holding registers. A separate load command then copies the held value into the active register that the accumulator reads, so a new tuning word takes effect all at once.

The write strobe and the two load commands are treated as asynchronous. Each passes through a two-flop synchroniser and an edge detector. The address picks one of three things: an 8-bit lane of the frequency word, for hosts with narrow buses; the whole frequency word in one write; or the phase word, alone or together with the frequency word. Transfers into the active registers are aligned to a divide-by-two load clock. Frequency transfers are rate-limited: a request that comes too soon after the previous accepted one is dropped and flagged.

Top module: `bcd_tune_loader`

## Requirements
- R1: While `rst_n` is low, every holding register and active register is cleared, and `load_clk`, `freq_upd`, `phase_upd` and `freq_overrun` are all 0.
- R2: A write is captured after a rising edge of `wr_strobe`, and only when `cs_n` is low. With `cs_n` high, the write changes no holding register.
- R3: Addresses 0 to 3 write `data_bus[7:0]` into frequency bits [8a+7:8a]. Address 4 writes `data_bus[2:0]` into bits [34:32]. All other bits keep their values, so lanes may be written in any order and only changed lanes need to be rewritten.
- R4: Address 6 writes all 35 frequency bits from `data_bus[34:0]`. Address 5 writes the phase holding register from `phase_in`. Address 7 does both in one write.
- R5: `load_clk` is 0 in reset and toggles on every rising clock edge after reset.
- R6: After a falling edge of `freq_load`, the held frequency word is copied to `freq_word` on the first rising clock edge at which `load_clk` is low. This edge is the third or fourth clock after the input changes. `freq_upd` pulses for one cycle with the new value, while `load_clk` reads 1.
- R7: `phase_load` works the same way as in R6, but for `phase_word` and `phase_upd`.
- R8: A frequency-load request is accepted only if it is detected at least 9 clocks after the previous accepted one. A rejected request leaves `freq_word` unchanged, produces no `freq_upd`, and sets `freq_overrun`, which stays set until reset.
- R9: The active words change only when a transfer occurs. Writing the holding registers without a load command leaves `freq_word` and `phase_word` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_strobe | input | 1 | Write strobe; a rising edge captures the buses |
| cs_n | input | 1 | Chip select, active low, gates writes |
| addr | input | 3 | Write target selector |
| data_bus | input | 35 | Frequency data; bits [7:0] carry the lane byte in lane mode |
| phase_in | input | 3 | Phase offset data |
| freq_load | input | 1 | Frequency transfer command, falling-edge active |
| phase_load | input | 1 | Phase transfer command, falling-edge active |
| load_clk | output | 1 | Clock divided by two; transfers occur while it is low |
| freq_word | output | 35 | Active BCD frequency word |
| phase_word | output | 3 | Active phase offset |
| freq_upd | output | 1 | One-cycle pulse on a frequency transfer |
| phase_upd | output | 1 | One-cycle pulse on a phase transfer |
| freq_overrun | output | 1 | Sticky flag for a rejected frequency load |

## Verification
The bench builds the block with its default parameters: a 35-bit word split into five 8-bit lanes, a 3-bit phase, a two-stage synchroniser and a 9-clock minimum spacing between frequency loads. With a 9-clock spacing, load requests can be placed exactly 9 and exactly 8 clocks apart, so the bench checks both sides of the acceptance limit. Because each load is issued with the current phase of `load_clk` known, the bench can predict whether the transfer lands on the third or the fourth clock.

// File: rtl/tune_pkg.sv
package tune_pkg;

    typedef enum logic [1:0] {
        WR_LANE  = 2'd0,
        WR_PHASE = 2'd1,
        WR_FREQ  = 2'd2,
        WR_BOTH  = 2'd3
    } wr_kind_e;

    // Lane codes sit at the bottom of the address space; the three
    // full-width codes follow directly after the last lane.
    function automatic wr_kind_e decode_addr(input int unsigned a,
                                             input int unsigned lanes);
        if (a < lanes)          return WR_LANE;
        else if (a == lanes)    return WR_PHASE;
        else if (a == lanes + 1) return WR_FREQ;
        else                    return WR_BOTH;
    endfunction

endpackage

// File: rtl/tune_edge_sync.sv
module tune_edge_sync #(
    parameter int   STAGES = 2,
    parameter logic IDLE   = 1'b0,
    parameter bit   RISE   = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic evt
);
    typedef struct packed {
        logic [STAGES:0] chain;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d.chain = {st_q.chain[STAGES-1:0], din};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{chain: {(STAGES+1){IDLE}}};
        else        st_q <= st_d;
    end

    generate
        if (RISE) begin : g_rise
            assign evt = st_q.chain[STAGES-1] & ~st_q.chain[STAGES];
        end else begin : g_fall
            assign evt = ~st_q.chain[STAGES-1] & st_q.chain[STAGES];
        end
    endgenerate

endmodule

// File: rtl/tune_buffers.sv
module tune_buffers
    import tune_pkg::*;
#(
    parameter int FREQ_W  = 35,
    parameter int PHASE_W = 3,
    parameter int BYTE_W  = 8,
    parameter int ADDR_W  = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_pulse,
    input  logic               cs_n,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [FREQ_W-1:0]  data,
    input  logic [PHASE_W-1:0] phase_in,
    output logic [FREQ_W-1:0]  freq_buf,
    output logic [PHASE_W-1:0] phase_buf
);
    localparam int LANES  = (FREQ_W + BYTE_W - 1) / BYTE_W;
    localparam int WIDE_W = LANES * BYTE_W;

    typedef struct packed {
        logic [FREQ_W-1:0]  freq;
        logic [PHASE_W-1:0] phase;
    } buf_t;

    buf_t               st_d, st_q;
    logic [WIDE_W-1:0]  wide;
    wr_kind_e           kind;

    always_comb begin
        st_d = st_q;
        kind = decode_addr(int'(addr), LANES);
        wide = WIDE_W'(st_q.freq);
        if (wr_pulse && !cs_n) begin
            unique case (kind)
                WR_LANE: begin
                    for (int i = 0; i < LANES; i++) begin
                        if (addr == ADDR_W'(i))
                            wide[i*BYTE_W +: BYTE_W] = data[BYTE_W-1:0];
                    end
                    st_d.freq = wide[FREQ_W-1:0];
                end
                WR_PHASE: st_d.phase = phase_in;
                WR_FREQ:  st_d.freq  = data;
                WR_BOTH: begin
                    st_d.freq  = data;
                    st_d.phase = phase_in;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign freq_buf  = st_q.freq;
    assign phase_buf = st_q.phase;

    // R2: a deselected write leaves both holding registers alone
    a_r2_cs_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_pulse && cs_n) |=> ($stable(freq_buf) && $stable(phase_buf)));

    // R3: writing the lowest lane keeps every higher bit
    a_r3_other_lanes: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_pulse && !cs_n && addr == '0)
        |=> (freq_buf[FREQ_W-1:BYTE_W] == $past(freq_buf[FREQ_W-1:BYTE_W])));

    // R4: a full-width frequency write takes the whole bus
    a_r4_full_word: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_pulse && !cs_n && kind == WR_FREQ) |=> (freq_buf == $past(data)));

endmodule

// File: rtl/tune_xfer.sv
module tune_xfer #(
    parameter int FREQ_W  = 35,
    parameter int PHASE_W = 3,
    parameter int MIN_GAP = 9
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               freq_req,
    input  logic               phase_req,
    input  logic [FREQ_W-1:0]  freq_buf,
    input  logic [PHASE_W-1:0] phase_buf,
    output logic               load_clk,
    output logic [FREQ_W-1:0]  freq_word,
    output logic [PHASE_W-1:0] phase_word,
    output logic               freq_upd,
    output logic               phase_upd,
    output logic               overrun
);
    localparam int GAP_W = $clog2(MIN_GAP + 1);

    typedef struct packed {
        logic               lclk;
        logic               fpend;
        logic               ppend;
        logic [GAP_W-1:0]   gap;
        logic [FREQ_W-1:0]  fword;
        logic [PHASE_W-1:0] pword;
        logic               fupd;
        logic               pupd;
        logic               ovr;
    } xfer_t;

    xfer_t st_d, st_q;
    logic  f_want, p_want;

    always_comb begin
        st_d      = st_q;
        st_d.lclk = ~st_q.lclk;
        st_d.fupd = 1'b0;
        st_d.pupd = 1'b0;
        if (st_q.gap != '0) st_d.gap = st_q.gap - 1'b1;

        f_want = st_q.fpend;
        if (freq_req) begin
            if (st_q.gap == '0) begin
                f_want   = 1'b1;
                st_d.gap = GAP_W'(MIN_GAP - 1);
            end else begin
                st_d.ovr = 1'b1;
            end
        end
        if (f_want) begin
            if (!st_q.lclk) begin
                st_d.fword = freq_buf;
                st_d.fupd  = 1'b1;
                st_d.fpend = 1'b0;
            end else begin
                st_d.fpend = 1'b1;
            end
        end

        p_want = st_q.ppend | phase_req;
        if (p_want) begin
            if (!st_q.lclk) begin
                st_d.pword = phase_buf;
                st_d.pupd  = 1'b1;
                st_d.ppend = 1'b0;
            end else begin
                st_d.ppend = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign load_clk   = st_q.lclk;
    assign freq_word  = st_q.fword;
    assign phase_word = st_q.pword;
    assign freq_upd   = st_q.fupd;
    assign phase_upd  = st_q.pupd;
    assign overrun    = st_q.ovr;

    // R6: frequency transfers happen on an edge where the divider was low
    a_r6_freq_on_low: assert property (@(posedge clk) disable iff (!rst_n)
        freq_upd |-> load_clk);

    // R7: same alignment for phase transfers
    a_r7_phase_on_low: assert property (@(posedge clk) disable iff (!rst_n)
        phase_upd |-> load_clk);

    // R8: the overrun flag never clears outside reset
    a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |=> overrun);

    // R9: active words move only together with their update pulse
    a_r9_freq_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !freq_upd |-> $stable(freq_word));
    a_r9_phase_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !phase_upd |-> $stable(phase_word));

endmodule

// File: rtl/bcd_tune_loader.sv
module bcd_tune_loader #(
    parameter int FREQ_W      = 35,
    parameter int PHASE_W     = 3,
    parameter int BYTE_W      = 8,
    parameter int ADDR_W      = 3,
    parameter int MIN_GAP     = 9,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_strobe,
    input  logic               cs_n,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [FREQ_W-1:0]  data_bus,
    input  logic [PHASE_W-1:0] phase_in,
    input  logic               freq_load,
    input  logic               phase_load,
    output logic               load_clk,
    output logic [FREQ_W-1:0]  freq_word,
    output logic [PHASE_W-1:0] phase_word,
    output logic               freq_upd,
    output logic               phase_upd,
    output logic               freq_overrun
);
    localparam int   N_SYNC     = 3;
    localparam logic [N_SYNC-1:0] IDLE_LVL  = 3'b110;  // strobe idles low, loads idle high
    localparam logic [N_SYNC-1:0] RISE_SENS = 3'b001;  // strobe acts on rise, loads on fall

    logic [N_SYNC-1:0] raw_in;
    logic [N_SYNC-1:0] evt;
    logic [FREQ_W-1:0]  freq_buf;
    logic [PHASE_W-1:0] phase_buf;

    assign raw_in = {phase_load, freq_load, wr_strobe};

    genvar g;
    generate
        for (g = 0; g < N_SYNC; g++) begin : g_sync
            tune_edge_sync #(
                .STAGES (SYNC_STAGES),
                .IDLE   (IDLE_LVL[g]),
                .RISE   (RISE_SENS[g])
            ) u_sync (
                .clk   (clk),
                .rst_n (rst_n),
                .din   (raw_in[g]),
                .evt   (evt[g])
            );
        end
    endgenerate

    tune_buffers #(
        .FREQ_W  (FREQ_W),
        .PHASE_W (PHASE_W),
        .BYTE_W  (BYTE_W),
        .ADDR_W  (ADDR_W)
    ) u_buf (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_pulse  (evt[0]),
        .cs_n      (cs_n),
        .addr      (addr),
        .data      (data_bus),
        .phase_in  (phase_in),
        .freq_buf  (freq_buf),
        .phase_buf (phase_buf)
    );

    tune_xfer #(
        .FREQ_W  (FREQ_W),
        .PHASE_W (PHASE_W),
        .MIN_GAP (MIN_GAP)
    ) u_xfer (
        .clk        (clk),
        .rst_n      (rst_n),
        .freq_req   (evt[1]),
        .phase_req  (evt[2]),
        .freq_buf   (freq_buf),
        .phase_buf  (phase_buf),
        .load_clk   (load_clk),
        .freq_word  (freq_word),
        .phase_word (phase_word),
        .freq_upd   (freq_upd),
        .phase_upd  (phase_upd),
        .overrun    (freq_overrun)
    );

endmodule

// File: tb/bcd_tune_loader_test.sv
`timescale 1ns/1ps
module bcd_tune_loader_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_strobe = 1'b0;
    logic        cs_n = 1'b1;
    logic [2:0]  addr = '0;
    logic [34:0] data_bus = '0;
    logic [2:0]  phase_in = '0;
    logic        freq_load = 1'b1;
    logic        phase_load = 1'b1;
    logic        load_clk;
    logic [34:0] freq_word;
    logic [2:0]  phase_word;
    logic        freq_upd, phase_upd, freq_overrun;

    int checks = 0;
    int fails  = 0;
    logic [34:0] fq[$];
    logic [2:0]  pq[$];

    always #4 clk = ~clk;

    bcd_tune_loader uut (
        .clk(clk), .rst_n(rst_n), .wr_strobe(wr_strobe), .cs_n(cs_n),
        .addr(addr), .data_bus(data_bus), .phase_in(phase_in),
        .freq_load(freq_load), .phase_load(phase_load),
        .load_clk(load_clk), .freq_word(freq_word), .phase_word(phase_word),
        .freq_upd(freq_upd), .phase_upd(phase_upd), .freq_overrun(freq_overrun)
    );

    task automatic chk(input bit ok, input string tag,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [2:0] a, input logic [34:0] d,
                             input logic [2:0] p, input logic sel_n);
        @(negedge clk);
        addr = a; data_bus = d; phase_in = p; cs_n = sel_n; wr_strobe = 1'b1;
        repeat (2) @(negedge clk);
        wr_strobe = 1'b0;
        repeat (2) @(negedge clk);
        cs_n = 1'b1;
    endtask

    // Drops freq_load, watches five negedges, raises it again.
    task automatic freq_pulse(input logic [34:0] exp, input bit accept, input string tag);
        int exp_lat, got;
        @(negedge clk);
        exp_lat = load_clk ? 4 : 3;
        if (accept) fq.push_back(exp);
        freq_load = 1'b0;
        got = 0;
        for (int k = 1; k <= 5; k++) begin
            @(negedge clk);
            if (freq_upd && got == 0) got = k;
        end
        freq_load = 1'b1;
        if (accept) chk(got == exp_lat, {tag, " R6 latency"}, 64'(got), 64'(exp_lat));
        else        chk(got == 0, {tag, " R8 rejected load pulsed"}, 64'(got), 64'd0);
    endtask

    task automatic phase_pulse(input logic [2:0] exp, input string tag);
        int exp_lat, got;
        @(negedge clk);
        exp_lat = load_clk ? 4 : 3;
        pq.push_back(exp);
        phase_load = 1'b0;
        got = 0;
        for (int k = 1; k <= 5; k++) begin
            @(negedge clk);
            if (phase_upd && got == 0) got = k;
        end
        phase_load = 1'b1;
        chk(got == exp_lat, {tag, " R7 latency"}, 64'(got), 64'(exp_lat));
    endtask

    // Scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && freq_upd) begin
            chk(load_clk == 1'b1, "R6 load_clk during freq_upd", 64'(load_clk), 64'd1);
            if (fq.size() == 0) chk(1'b0, "R8 unexpected freq_upd", 64'(freq_word), 64'd0);
            else begin
                logic [34:0] e;
                e = fq.pop_front();
                chk(freq_word == e, "R6 freq_word", 64'(freq_word), 64'(e));
            end
        end
        if (rst_n && phase_upd) begin
            chk(load_clk == 1'b1, "R7 load_clk during phase_upd", 64'(load_clk), 64'd1);
            if (pq.size() == 0) chk(1'b0, "R7 unexpected phase_upd", 64'(phase_word), 64'd0);
            else begin
                logic [2:0] e;
                e = pq.pop_front();
                chk(phase_word == e, "R7 phase_word", 64'(phase_word), 64'(e));
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++; fails++;
        $display("FAIL R6 watchdog actual=running expected=finished");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        logic prev;
        logic [34:0] held;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(freq_word == '0, "R1 freq_word", 64'(freq_word), 64'd0);
        chk(phase_word == '0, "R1 phase_word", 64'(phase_word), 64'd0);
        chk(load_clk == 1'b0, "R1 load_clk", 64'(load_clk), 64'd0);
        chk(!freq_upd && !phase_upd, "R1 update pulses", 64'({freq_upd, phase_upd}), 64'd0);
        chk(freq_overrun == 1'b0, "R1 overrun", 64'(freq_overrun), 64'd0);
        rst_n = 1'b1;

        // R5: divider toggles every clock
        @(negedge clk);
        prev = load_clk;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            chk(load_clk != prev, "R5 load_clk toggle", 64'(load_clk), 64'(!prev));
            prev = load_clk;
        end

        // R3: lanes in scrambled order
        bus_write(3'd3, 35'h12, 3'd0, 1'b0);
        bus_write(3'd0, 35'h78, 3'd0, 1'b0);
        bus_write(3'd4, 35'h05, 3'd0, 1'b0);
        bus_write(3'd2, 35'h34, 3'd0, 1'b0);
        bus_write(3'd1, 35'h56, 3'd0, 1'b0);
        // R9: buffered only, active word untouched
        chk(freq_word == '0, "R9 freq_word before load", 64'(freq_word), 64'd0);
        freq_pulse(35'h5_1234_5678, 1'b1, "R3 lane assembly");

        // R3: rewrite one lane only
        bus_write(3'd1, 35'h99, 3'd0, 1'b0);
        freq_pulse(35'h5_1234_9978, 1'b1, "R3 single lane");

        // R2: deselected write ignored
        bus_write(3'd6, 35'h7_7777_7777, 3'd0, 1'b1);
        freq_pulse(35'h5_1234_9978, 1'b1, "R2 cs_n high");

        // R4: full-width write
        bus_write(3'd6, 35'h3_0102_0304, 3'd0, 1'b0);
        freq_pulse(35'h3_0102_0304, 1'b1, "R4 parallel");

        // R4/R7: phase-only write
        bus_write(3'd5, 35'h0, 3'd3, 1'b0);
        phase_pulse(3'd3, "R4 phase write");
        chk(freq_word == 35'h3_0102_0304, "R7 freq untouched by phase load",
            64'(freq_word), 64'h3_0102_0304);

        // R4: combined write
        bus_write(3'd7, 35'h6_9876_5432, 3'd6, 1'b0);
        freq_pulse(35'h6_9876_5432, 1'b1, "R4 combined freq");
        phase_pulse(3'd6, "R4 combined phase");

        // R8: spacing of exactly the limit is accepted
        repeat (10) @(negedge clk);
        freq_pulse(35'h6_9876_5432, 1'b1, "R8 first");
        repeat (3) @(negedge clk);   // falls 9 clocks apart
        freq_pulse(35'h6_9876_5432, 1'b1, "R8 gap 9");
        chk(freq_overrun == 1'b0, "R8 overrun after gap 9", 64'(freq_overrun), 64'd0);

        // R8: one clock short is rejected
        bus_write(3'd6, 35'h1_1111_1111, 3'd0, 1'b0);
        freq_pulse(35'h1_1111_1111, 1'b1, "R8 base");
        repeat (2) @(negedge clk);   // falls 8 clocks apart
        held = freq_word;
        freq_pulse(35'h0, 1'b0, "R8 gap 8");
        chk(freq_overrun == 1'b1, "R8 overrun set", 64'(freq_overrun), 64'd1);
        chk(freq_word == held, "R8 word kept", 64'(freq_word), 64'(held));

        // R8: later load still works, flag stays
        repeat (12) @(negedge clk);
        freq_pulse(35'h1_1111_1111, 1'b1, "R8 recovery");
        chk(freq_overrun == 1'b1, "R8 overrun sticky", 64'(freq_overrun), 64'd1);

        repeat (4) @(negedge clk);
        chk(fq.size() == 0, "R6 pending freq items", 64'(fq.size()), 64'd0);
        chk(pq.size() == 0, "R7 pending phase items", 64'(pq.size()), 64'd0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule